// File: doc/BRIEF.md
# Guarded Multi-Port VLIW Register File

This block is the general-purpose register array of a five-slot very long instruction word core. It holds 128 registers of 32 bits. Every issue slot gets three combinational read ports (two source operands and one guard operand) and one write-back lane, so 15 reads and 5 writes are served each clock cycle. Registers 0 and 1 are fixed constants (0 and 1), which lets an unguarded operation name register 1 as its guard and always write.

There are no status flags in the core: compare operations leave a bit pattern in an ordinary register, and a later operation uses that register as its guard. The issue logic reads the guard register through the slot's third read port, takes bit 0 as the guard condition and carries it down the pipeline with the result. A write-back lane commits only when its enable and its carried guard bit are both high. When two effective lanes name the same register in one cycle, the higher-numbered lane wins and a conflict flag is raised for that cycle. A read of a register being written in the same cycle returns the value held before the write. Bypassing is handled outside this block.

Top module: `vliw_guarded_regfile`

## Requirements
- R1: The array holds 128 registers of 32 bits, and any of registers 2 to 127 reads back the last committed value on each of the 15 read ports.
- R2: An address of 0 reads as 32'd0 and an address of 1 reads as 32'd1 on every read port, in every cycle.
- R3: A lane that targets register 0 or 1 changes nothing, even with enable and guard high. Reads of 0 and 1 keep their constants and no other register is altered.
- R4: A lane commits only when `wr_en[l]` and `wr_guard[l]` are both 1. With the guard at 0, the target register keeps its previous value.
- R5: Up to five lanes aimed at distinct registers all commit on the same rising clock edge. Lane l uses `wr_addr[7*l +: 7]` and `wr_data[32*l +: 32]`.
- R6: During the cycle in which a register is being written, a read of it returns the old value. The new value appears from the cycle after the clock edge.
- R7: When two or more effective lanes target the same register, the highest-numbered lane's data is stored, and `wr_conflict` is 1 combinationally in that cycle.
- R8: `wr_conflict` considers only effective lanes: enable high, guard high and target address 2 or above. Colliding lanes that are guarded off or aimed at registers 0 or 1 leave it at 0.
- R9: While `rst_n` is low, registers 2 to 127 are cleared to zero (asynchronous, active low).
- R10: Read ports are combinational. Read port p uses `rd_addr[7*p +: 7]` and returns data on `rd_data[32*p +: 32]` in the same cycle. Port p = 3*slot + k, where k=0 is the first source, k=1 the second source and k=2 the guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 105 | Fifteen 7-bit read addresses, port p at bits 7*p |
| rd_data | output | 480 | Fifteen 32-bit read results, port p at bits 32*p |
| wr_en | input | 5 | Write request per lane |
| wr_guard | input | 5 | Guard bit carried with each lane (bit 0 of its guard register at issue) |
| wr_addr | input | 35 | Five 7-bit write targets |
| wr_data | input | 160 | Five 32-bit write values |
| wr_conflict | output | 1 | Two or more effective lanes share a target this cycle |

## Verification
Assertions check the following on every cycle:
- Registers 0 and 1 are never written in storage.
- No two winning lanes share a target.
- A raised conflict flag always means some requesting lane was dropped.
- Every winning lane's data is present in the array on the next cycle.
- A cycle with no guarded-true request leaves the whole array unchanged.
- The array is zero when reset is released.

Only the bench scenarios show the following:
- The data values seen at the read ports.
- That the higher lane's data wins a collision.
- That old data is returned while a write is pending.
- That guarded-off or constant-target collisions keep the flag low.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int RF_NUM_REGS    = 128;
    localparam int RF_DATA_W      = 32;
    localparam int RF_NUM_SLOTS   = 5;
    localparam int RF_RD_PER_SLOT = 3;
    // Lowest address backed by real storage; lower addresses are constants.
    localparam int RF_FIRST_STORED = 2;
endpackage

// File: rtl/rf_write_arbiter.sv
module rf_write_arbiter #(
    parameter int NUM_SLOTS = rf_pkg::RF_NUM_SLOTS,
    parameter int ADDR_W    = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SLOTS-1:0]        wr_en,
    input  logic [NUM_SLOTS-1:0]        wr_guard,
    input  logic [NUM_SLOTS*ADDR_W-1:0] wr_addr,
    output logic [NUM_SLOTS-1:0]        lane_win,
    output logic                        conflict
);
    logic [NUM_SLOTS-1:0] effective;

    always_comb begin
        for (int l = 0; l < NUM_SLOTS; l++) begin
            effective[l] = wr_en[l] && wr_guard[l] &&
                           (int'(wr_addr[l*ADDR_W +: ADDR_W]) >= rf_pkg::RF_FIRST_STORED);
        end
        lane_win = effective;
        conflict = 1'b0;
        for (int lo = 0; lo < NUM_SLOTS; lo++) begin
            for (int hi = lo + 1; hi < NUM_SLOTS; hi++) begin
                if (effective[lo] && effective[hi] &&
                    wr_addr[lo*ADDR_W +: ADDR_W] == wr_addr[hi*ADDR_W +: ADDR_W]) begin
                    lane_win[lo] = 1'b0;
                    conflict     = 1'b1;
                end
            end
        end
    end

    // A raised flag means at least one guarded-true request was dropped.
    AST_CONFLICT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> ($countones(lane_win) < $countones(wr_en & wr_guard))); // R7

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pair_i
            for (genvar j = i + 1; j < NUM_SLOTS; j++) begin : g_pair_j
                AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
                    !(lane_win[i] && lane_win[j] &&
                      wr_addr[i*ADDR_W +: ADDR_W] == wr_addr[j*ADDR_W +: ADDR_W])); // R7
            end
        end
    endgenerate
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
    output logic [DATA_W-1:0]                rd_data
);
    always_comb begin
        if (int'(rd_addr) == 0) begin
            rd_data = '0;
        end else if (int'(rd_addr) == 1) begin
            rd_data = DATA_W'(1);
        end else if (int'(rd_addr) < NUM_REGS) begin
            rd_data = regs[rd_addr];
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/vliw_guarded_regfile.sv
module vliw_guarded_regfile #(
    parameter int NUM_REGS    = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W      = rf_pkg::RF_DATA_W,
    parameter int NUM_SLOTS   = rf_pkg::RF_NUM_SLOTS,
    parameter int RD_PER_SLOT = rf_pkg::RF_RD_PER_SLOT,
    localparam int ADDR_W     = $clog2(NUM_REGS),
    localparam int NUM_RD     = NUM_SLOTS * RD_PER_SLOT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_RD*ADDR_W-1:0]    rd_addr,
    output logic [NUM_RD*DATA_W-1:0]    rd_data,
    input  logic [NUM_SLOTS-1:0]        wr_en,
    input  logic [NUM_SLOTS-1:0]        wr_guard,
    input  logic [NUM_SLOTS*ADDR_W-1:0] wr_addr,
    input  logic [NUM_SLOTS*DATA_W-1:0] wr_data,
    output logic                        wr_conflict
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t            state_d, state_q;
    logic [NUM_SLOTS-1:0] lane_win;

    rf_write_arbiter #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W)
    ) arb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_guard (wr_guard),
        .wr_addr  (wr_addr),
        .lane_win (lane_win),
        .conflict (wr_conflict)
    );

    always_comb begin
        state_d = state_q;
        for (int l = 0; l < NUM_SLOTS; l++) begin
            if (lane_win[l]) begin
                state_d.regs[wr_addr[l*ADDR_W +: ADDR_W]] = wr_data[l*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    generate
        for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
            rf_read_port #(
                .NUM_REGS (NUM_REGS),
                .DATA_W   (DATA_W),
                .ADDR_W   (ADDR_W)
            ) port_i (
                .rd_addr (rd_addr[p*ADDR_W +: ADDR_W]),
                .regs    (state_q.regs),
                .rd_data (rd_data[p*DATA_W +: DATA_W])
            );
        end

        for (genvar l = 0; l < NUM_SLOTS; l++) begin : g_lane_chk
            AST_WIN_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
                lane_win[l] |=> (state_q.regs[$past(wr_addr[l*ADDR_W +: ADDR_W])]
                                 == $past(wr_data[l*DATA_W +: DATA_W]))); // R5
        end
    endgenerate

    AST_CONST_SLOTS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.regs[0] == '0) && (state_q.regs[1] == '0)); // R3

    AST_UNGUARDED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en & wr_guard) == '0) |=> $stable(state_q)); // R4

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == '0)); // R9
endmodule

// File: tb/vliw_guarded_regfile_tb.sv
module vliw_guarded_regfile_tb_top;
    localparam int AW = 7;
    localparam int DW = 32;
    localparam int NS = 5;
    localparam int NR = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NR*AW-1:0]  rd_addr = '0;
    logic [NR*DW-1:0]  rd_data;
    logic [NS-1:0]     wr_en = '0;
    logic [NS-1:0]     wr_guard = '0;
    logic [NS*AW-1:0]  wr_addr = '0;
    logic [NS*DW-1:0]  wr_data = '0;
    logic              wr_conflict;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [128];

    always #10 clk = ~clk;

    vliw_guarded_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_guard(wr_guard), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_conflict(wr_conflict)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 128; i++) model[i] = '0;
        model[1] = 32'd1;
    endtask

    task automatic drive_lane(int l, bit en, bit g, int a, logic [DW-1:0] d);
        wr_en[l] = en;
        wr_guard[l] = g;
        wr_addr[l*AW +: AW] = AW'(a);
        wr_data[l*DW +: DW] = d;
    endtask

    function automatic bit exp_conflict();
        bit c = 1'b0;
        for (int i = 0; i < NS; i++)
            for (int j = i + 1; j < NS; j++)
                if (wr_en[i] && wr_guard[i] && wr_en[j] && wr_guard[j] &&
                    wr_addr[i*AW +: AW] == wr_addr[j*AW +: AW] &&
                    int'(wr_addr[i*AW +: AW]) >= 2)
                    c = 1'b1;
        return c;
    endfunction

    // Called shortly after a falling edge with lanes driven.
    task automatic commit(string req);
        #2;
        check(req, {31'd0, wr_conflict}, {31'd0, exp_conflict()});
        for (int l = 0; l < NS; l++)
            if (wr_en[l] && wr_guard[l] && int'(wr_addr[l*AW +: AW]) >= 2)
                model[int'(wr_addr[l*AW +: AW])] = wr_data[l*DW +: DW];
        @(posedge clk);
        @(negedge clk);
        wr_en = '0;
        wr_guard = '0;
    endtask

    // Reads base..base+14 (wrapping) on all 15 ports; called in the low phase.
    task automatic check_all(string req, int base);
        for (int p = 0; p < NR; p++) rd_addr[p*AW +: AW] = AW'((base + p) % 128);
        #2;
        for (int p = 0; p < NR; p++)
            check(req, rd_data[p*DW +: DW], model[(base + p) % 128]);
    endtask

    task automatic t_reset();
        model_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R9 reset", 0);
        check_all("R2 consts in reset", 126);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 after release", 60);
    endtask

    task automatic t_parallel();
        for (int l = 0; l < NS; l++) drive_lane(l, 1, 1, 10 + l, 32'hA000_0000 + l * 32'h111);
        rd_addr[0 +: AW] = AW'(12);
        #1;
        check("R6 old value during write", rd_data[0 +: DW], 32'd0);
        commit("R5 no conflict distinct");
        check_all("R5 five writes R1 R10", 5);
    endtask

    task automatic t_guard();
        drive_lane(0, 1, 0, 20, 32'hDEAD_BEEF);
        drive_lane(1, 1, 1, 21, 32'h1234_5678);
        drive_lane(2, 0, 1, 22, 32'hFFFF_FFFF);
        commit("R4 guard conflict flag");
        check_all("R4 guard gating", 18);
    endtask

    task automatic t_const();
        drive_lane(0, 1, 1, 0, 32'hFFFF_FFFF);
        drive_lane(3, 1, 1, 0, 32'h5555_5555);
        drive_lane(4, 1, 1, 1, 32'hAAAA_AAAA);
        commit("R8 const targets no conflict");
        check_all("R3 consts kept", 0);
        check_all("R2 every port const", 127);
    endtask

    task automatic t_conflict();
        drive_lane(1, 1, 1, 30, 32'h1111_1111);
        drive_lane(3, 1, 1, 30, 32'h3333_3333);
        drive_lane(0, 1, 1, 30, 32'h0000_0F0F);
        commit("R7 conflict flag");
        rd_addr[0 +: AW] = AW'(30);
        #2;
        check("R7 highest lane wins", rd_data[0 +: DW], 32'h3333_3333);
        @(negedge clk);
        drive_lane(2, 1, 0, 31, 32'h2222_2222);
        drive_lane(4, 1, 1, 31, 32'h4444_4444);
        commit("R8 guarded-off collision no flag");
        check_all("R8 collision data", 25);
    endtask

    task automatic t_spread();
        for (int l = 0; l < NS; l++) drive_lane(l, 1, 1, 127 - 13 * l, 32'hC0DE_0000 ^ (l << 8));
        commit("R5 spread");
        for (int b = 0; b < 128; b += 15) check_all("R1 full sweep", b);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        t_reset();
        t_parallel();
        t_guard();
        t_const();
        t_conflict();
        t_spread();
        @(negedge clk);
        t_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule